// File: doc/BRIEF.md
# Power-Mode Clock Enable Controller

This block sits between a free-running master clock and the clocked logic of a small processor subsystem. It divides the master clock down to a half-rate system clock. At each half-rate edge it produces one-cycle clock-enable pulses for the core, the memory, every peripheral and a watchdog. Each enable is active or gated according to the current power mode. Three modes exist: Run, Wait and Stop. The core asks to enter Wait or Stop through request inputs. The controller returns to Run only on the wake events that the current mode accepts.

Software can switch any peripheral clock on or off through a per-peripheral enable register. The watchdog enable does not pass through the peripheral gating and keeps pulsing in every mode. The controller samples all request, wake and write inputs only on half-rate edges, so a mode change never produces a partial enable pulse. A power-on reset, an external reset request or a watchdog reset request returns the controller to Run with every peripheral enabled, and a reset-cause output records which source acted.

Top module: `pmode_clkctl`

## Requirements
- R1: `sys_tick` and every clock-enable output are high for at most one master cycle in every two, and they rise together on half-rate edges.
- R2: After `rst`, `mode` reads Run (encoding 0), `rst_cause` reads power-on (encoding 0), all peripheral enable bits are 1, and core, memory and all peripheral enables pulse.
- R3: The `mode` encodings are Run=0, Wait=1 and Stop=2. In Run, `stop_req` enters Stop, and `wait_req` enters Wait when `stop_req` is low. Stop wins when both are high.
- R4: In Wait, `core_ce` and `mem_ce` stay low, and `per_ce[i]` pulses whenever enable bit i is 1.
- R5: Wait returns to Run when any bit of `irq_pend & irq_en` is 1 at a half-rate edge. A pending interrupt whose `irq_en` bit is 0 has no effect.
- R6: In Stop, core, memory and all peripheral enables stay low. `wait_req` and peripheral interrupts do not wake the block.
- R7: Stop returns to Run on `nclk_irq` or `can_act`. `can_lost` pulses for one master cycle, together with the first Run enables, exactly when `can_act` was high at that wake edge.
- R8: `pce_wr` loads `pce_wdata` into the peripheral enable register at a half-rate edge in any mode. Bit i = 0 holds `per_ce[i]` low, and the register keeps its value across mode changes.
- R9: `wdog_ce` pulses once every two master cycles in Run, Wait and Stop.
- R10: `ext_rst_req` or `wdog_rst_req` at a half-rate edge forces Run from any mode and sets all peripheral enable bits to 1. It sets `rst_cause` to external (1) or watchdog (2). External wins when both are high.
- R11: Inputs are sampled only on half-rate edges. `mode` changes only in cycles where `sys_tick` is high, and a request held only during the cycle between edges has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_req | input | 1 | External reset request |
| wdog_rst_req | input | 1 | Watchdog reset request |
| wait_req | input | 1 | Core request to enter Wait |
| stop_req | input | 1 | Core request to enter Stop |
| irq_pend | input | NPER | Pending peripheral interrupts |
| irq_en | input | NPER | Interrupt mask, 1 = unmasked |
| nclk_irq | input | 1 | Interrupt that needs no clock (Stop wake) |
| can_act | input | 1 | CAN bus activity (Stop wake) |
| pce_wr | input | 1 | Write strobe for the peripheral enable register |
| pce_wdata | input | NPER | Data for the peripheral enable register |
| sys_tick | output | 1 | Ungated half-rate tick |
| core_ce | output | 1 | Core clock enable |
| mem_ce | output | 1 | Memory clock enable |
| per_ce | output | NPER | Per-peripheral clock enables |
| wdog_ce | output | 1 | Watchdog clock enable |
| mode | output | 2 | Current mode |
| rst_cause | output | 2 | Last reset source |
| can_lost | output | 1 | Pulse: first CAN message lost on wake |

## Verification
A wrong mode state shows up on the enable outputs at the first half-rate edge after it arises. Examples are core pulses during Wait, peripheral pulses during Stop, or a missing Run after an unmasked interrupt, and each appears within two master cycles. A corrupted enable register shows as the wrong `per_ce` pattern on the next tick. A divider fault breaks the one-in-two pulse spacing of `sys_tick` and `wdog_ce` within a single half-rate period. The bench sweeps all enable-register values in each mode and every pending/mask combination out of Wait, so any single bit decoded wrongly is exposed.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    M_RUN  = 2'd0,
    M_WAIT = 2'd1,
    M_STOP = 2'd2
  } pmode_e;

  typedef enum logic [1:0] {
    RC_POR  = 2'd0,
    RC_EXT  = 2'd1,
    RC_WDOG = 2'd2
  } rcause_e;
endpackage

// File: rtl/pmc_halfrate.sv
module pmc_halfrate #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic edge_c,
  output logic sys_tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign edge_c = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sys_tick <= 1'b0;
    end else begin
      cnt      <= edge_c ? '0 : cnt + 1'b1;
      sys_tick <= edge_c;
    end
  end

  // R1: the tick never lasts two master cycles
  p_tick_spaced_r1: assert property (@(posedge clk) disable iff (rst)
    sys_tick |=> !sys_tick);
endmodule

// File: rtl/pmc_mode_ctl.sv
module pmc_mode_ctl
  import pmc_pkg::*;
#(
  parameter int NPER = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            edge_c,
  input  logic            ext_rst_req,
  input  logic            wdog_rst_req,
  input  logic            wait_req,
  input  logic            stop_req,
  input  logic [NPER-1:0] irq_pend,
  input  logic [NPER-1:0] irq_en,
  input  logic            nclk_irq,
  input  logic            can_act,
  input  logic            pce_wr,
  input  logic [NPER-1:0] pce_wdata,
  output pmode_e          mode_q,
  output pmode_e          mode_nx,
  output logic [NPER-1:0] pce_q,
  output logic [NPER-1:0] pce_nx,
  output rcause_e         cause_q,
  output logic            can_lost
);
  rcause_e cause_nx;
  logic    lost_nx;
  logic    irq_hit;

  assign irq_hit = |(irq_pend & irq_en);

  always_comb begin
    mode_nx  = mode_q;
    pce_nx   = pce_q;
    cause_nx = cause_q;
    lost_nx  = 1'b0;
    if (edge_c) begin
      if (ext_rst_req || wdog_rst_req) begin
        mode_nx  = M_RUN;
        pce_nx   = '1;
        cause_nx = ext_rst_req ? RC_EXT : RC_WDOG;
      end else begin
        if (pce_wr) pce_nx = pce_wdata;
        unique case (mode_q)
          M_RUN: begin
            if (stop_req)      mode_nx = M_STOP;
            else if (wait_req) mode_nx = M_WAIT;
          end
          M_WAIT: begin
            if (irq_hit) mode_nx = M_RUN;
          end
          M_STOP: begin
            if (nclk_irq || can_act) begin
              mode_nx = M_RUN;
              lost_nx = can_act;
            end
          end
          default: mode_nx = M_RUN;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_RUN;
      pce_q    <= '1;
      cause_q  <= RC_POR;
      can_lost <= 1'b0;
    end else begin
      mode_q   <= mode_nx;
      pce_q    <= pce_nx;
      cause_q  <= cause_nx;
      can_lost <= lost_nx;
    end
  end

  // R7: a lost-message pulse only accompanies a wake out of Stop
  p_lost_wake_r7: assert property (@(posedge clk) disable iff (rst)
    can_lost |-> (mode_q == M_RUN && $past(mode_q) == M_STOP));

  // R6: without an allowed wake source, Stop persists
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (edge_c && mode_q == M_STOP && !nclk_irq && !can_act && !ext_rst_req && !wdog_rst_req)
    |=> mode_q == M_STOP);

  // R10: a reset request restores Run and all peripheral enables
  p_rstreq_r10: assert property (@(posedge clk) disable iff (rst)
    (edge_c && (ext_rst_req || wdog_rst_req)) |=> (mode_q == M_RUN && pce_q == '1));
endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
  import pmc_pkg::*;
#(
  parameter int NPER = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            edge_c,
  input  pmode_e          mode_nx,
  input  pmode_e          mode_q,
  input  logic [NPER-1:0] pce_nx,
  output logic            core_ce,
  output logic            mem_ce,
  output logic [NPER-1:0] per_ce,
  output logic            wdog_ce
);
  logic run_nx, per_ok_nx;

  assign run_nx    = (mode_nx == M_RUN);
  assign per_ok_nx = (mode_nx != M_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      core_ce <= 1'b0;
      mem_ce  <= 1'b0;
      wdog_ce <= 1'b0;
    end else begin
      core_ce <= edge_c & run_nx;
      mem_ce  <= edge_c & run_nx;
      wdog_ce <= edge_c;
    end
  end

  for (genvar i = 0; i < NPER; i++) begin : g_per
    logic ce_r;
    always_ff @(posedge clk) begin
      if (rst) ce_r <= 1'b0;
      else     ce_r <= edge_c & per_ok_nx & pce_nx[i];
    end
    assign per_ce[i] = ce_r;
  end

  // R4: core and memory enables only pulse in Run
  p_core_run_r4: assert property (@(posedge clk) disable iff (rst)
    (core_ce || mem_ce) |-> mode_q == M_RUN);

  // R6: no peripheral enable pulses in Stop
  p_per_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (|per_ce) |-> mode_q != M_STOP);

  // R9: watchdog enable is a single-cycle pulse
  p_wdog_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    wdog_ce |=> !wdog_ce);
endmodule

// File: rtl/pmode_clkctl.sv
module pmode_clkctl
  import pmc_pkg::*;
#(
  parameter int NPER = 4,
  parameter int DIV  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_rst_req,
  input  logic            wdog_rst_req,
  input  logic            wait_req,
  input  logic            stop_req,
  input  logic [NPER-1:0] irq_pend,
  input  logic [NPER-1:0] irq_en,
  input  logic            nclk_irq,
  input  logic            can_act,
  input  logic            pce_wr,
  input  logic [NPER-1:0] pce_wdata,
  output logic            sys_tick,
  output logic            core_ce,
  output logic            mem_ce,
  output logic [NPER-1:0] per_ce,
  output logic            wdog_ce,
  output logic [1:0]      mode,
  output logic [1:0]      rst_cause,
  output logic            can_lost
);
  logic            edge_c;
  pmode_e          mode_q, mode_nx;
  logic [NPER-1:0] pce_q, pce_nx;
  rcause_e         cause_q;

  pmc_halfrate #(.DIV(DIV)) u_div (
    .clk      (clk),
    .rst      (rst),
    .edge_c   (edge_c),
    .sys_tick (sys_tick)
  );

  pmc_mode_ctl #(.NPER(NPER)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .edge_c       (edge_c),
    .ext_rst_req  (ext_rst_req),
    .wdog_rst_req (wdog_rst_req),
    .wait_req     (wait_req),
    .stop_req     (stop_req),
    .irq_pend     (irq_pend),
    .irq_en       (irq_en),
    .nclk_irq     (nclk_irq),
    .can_act      (can_act),
    .pce_wr       (pce_wr),
    .pce_wdata    (pce_wdata),
    .mode_q       (mode_q),
    .mode_nx      (mode_nx),
    .pce_q        (pce_q),
    .pce_nx       (pce_nx),
    .cause_q      (cause_q),
    .can_lost     (can_lost)
  );

  pmc_gate #(.NPER(NPER)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .edge_c  (edge_c),
    .mode_nx (mode_nx),
    .mode_q  (mode_q),
    .pce_nx  (pce_nx),
    .core_ce (core_ce),
    .mem_ce  (mem_ce),
    .per_ce  (per_ce),
    .wdog_ce (wdog_ce)
  );

  assign mode      = mode_q;
  assign rst_cause = cause_q;

  // R11: the mode only moves together with a half-rate tick
  p_mode_on_tick_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> sys_tick);

  // R8: a cleared enable bit keeps its peripheral silent
  p_pce_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (per_ce & ~pce_q) == '0);
endmodule

// File: tb/tb_pmode_clkctl.sv
module tb_pmode_clkctl;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst, ext_rst_req, wdog_rst_req, wait_req, stop_req, nclk_irq, can_act, pce_wr;
  logic [NP-1:0] irq_pend, irq_en, pce_wdata, per_ce;
  logic sys_tick, core_ce, mem_ce, wdog_ce, can_lost;
  logic [1:0] mode, rst_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pmode_clkctl #(.NPER(NP), .DIV(2)) dut (
    .clk(clk), .rst(rst), .ext_rst_req(ext_rst_req), .wdog_rst_req(wdog_rst_req),
    .wait_req(wait_req), .stop_req(stop_req), .irq_pend(irq_pend), .irq_en(irq_en),
    .nclk_irq(nclk_irq), .can_act(can_act), .pce_wr(pce_wr), .pce_wdata(pce_wdata),
    .sys_tick(sys_tick), .core_ce(core_ce), .mem_ce(mem_ce), .per_ce(per_ce),
    .wdog_ce(wdog_ce), .mode(mode), .rst_cause(rst_cause), .can_lost(can_lost)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one half-rate period: inputs set now are sampled, results shown at the end
  task automatic step();
    repeat (2) @(negedge clk);
  endtask

  task automatic align();
    @(negedge clk);
    while (!sys_tick) @(negedge clk);
  endtask

  task automatic count_pulses(input string tag, input int n, input int ecore, input int eper);
    int c_core = 0, c_mem = 0, c_per = 0, c_wd = 0, c_tk = 0;
    for (int k = 0; k < 2 * n; k++) begin
      c_core += core_ce; c_mem += mem_ce; c_per += per_ce[0];
      c_wd += wdog_ce; c_tk += sys_tick;
      @(negedge clk);
    end
    chk({tag, " R1 core_ce count"}, c_core, ecore);
    chk({tag, " R1 mem_ce count"}, c_mem, ecore);
    chk({tag, " R1 per_ce0 count"}, c_per, eper);
    chk({tag, " R9 wdog_ce count"}, c_wd, n);
    chk({tag, " R1 sys_tick count"}, c_tk, n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; ext_rst_req = 0; wdog_rst_req = 0; wait_req = 0; stop_req = 0;
    nclk_irq = 0; can_act = 0; pce_wr = 0; irq_pend = '0; irq_en = '0; pce_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    align();

    // R2 reset state
    chk("R2 mode", mode, 0);
    chk("R2 rst_cause", rst_cause, 0);
    chk("R2 per_ce", per_ce, 15);
    chk("R2 core_ce", core_ce, 1);
    chk("R2 mem_ce", mem_ce, 1);
    count_pulses("Run", 10, 10, 10);

    // R11 request only between edges is ignored
    wait_req = 1; @(negedge clk); wait_req = 0; @(negedge clk);
    chk("R11 short wait_req ignored", mode, 0);

    // R8 enable register sweep in Run
    for (int v = 0; v < 16; v++) begin
      pce_wr = 1; pce_wdata = NP'(v); step();
      chk("R8 per_ce in Run", per_ce, v);
      chk("R8 core_ce in Run", core_ce, 1);
    end
    pce_wdata = 4'hF; step(); pce_wr = 0;

    // R3 enter Wait
    wait_req = 1; step(); wait_req = 0;
    chk("R3 mode Wait", mode, 1);
    chk("R4 core_ce in Wait", core_ce, 0);
    chk("R4 mem_ce in Wait", mem_ce, 0);
    chk("R4 per_ce in Wait", per_ce, 15);
    count_pulses("Wait", 10, 0, 10);

    for (int v = 0; v < 16; v++) begin
      pce_wr = 1; pce_wdata = NP'(v); step();
      chk("R8 per_ce in Wait", per_ce, v);
    end
    pce_wdata = 4'hF; step(); pce_wr = 0;

    // R5 exhaustive pending/mask sweep out of Wait
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        irq_pend = NP'(p); irq_en = NP'(e); step();
        chk("R5 wake on unmasked irq", mode, ((p & e) != 0) ? 0 : 1);
        irq_pend = '0; irq_en = '0;
        if ((p & e) != 0) begin
          wait_req = 1; step(); wait_req = 0;
        end
      end
    end
    irq_pend = '0; irq_en = '0; step();
    chk("R5 stays in Wait", mode, 1);
    irq_pend = 4'h2; irq_en = 4'h2; step(); irq_pend = '0; irq_en = '0;
    chk("R5 back to Run", mode, 0);

    // R3 stop wins over wait
    stop_req = 1; wait_req = 1; step(); stop_req = 0; wait_req = 0;
    chk("R3 stop priority", mode, 2);
    chk("R6 per_ce in Stop", per_ce, 0);
    chk("R6 core_ce in Stop", core_ce, 0);
    count_pulses("Stop", 10, 0, 0);

    irq_pend = 4'hF; irq_en = 4'hF; wait_req = 1; step();
    irq_pend = '0; irq_en = '0; wait_req = 0;
    chk("R6 irq/wait ignored in Stop", mode, 2);
    chk("R6 per_ce still off", per_ce, 0);

    for (int v = 0; v < 16; v++) begin
      pce_wr = 1; pce_wdata = NP'(v); step();
      chk("R6 per_ce gated in Stop", per_ce, 0);
    end
    pce_wdata = 4'hA; step(); pce_wr = 0;

    // R7 wake via non-clocked interrupt
    nclk_irq = 1; step(); nclk_irq = 0;
    chk("R7 nclk wake mode", mode, 0);
    chk("R7 nclk wake no loss", can_lost, 0);
    chk("R8 pce kept across Stop", per_ce, 10);

    // R7 wake via CAN activity
    stop_req = 1; step(); stop_req = 0;
    can_act = 1; step(); can_act = 0;
    chk("R7 can wake mode", mode, 0);
    chk("R7 can_lost pulse", can_lost, 1);
    @(negedge clk);
    chk("R7 can_lost one cycle", can_lost, 0);
    @(negedge clk);

    stop_req = 1; step(); stop_req = 0;
    nclk_irq = 1; can_act = 1; step(); nclk_irq = 0; can_act = 0;
    chk("R7 both wake lost", can_lost, 1);
    @(negedge clk); @(negedge clk);

    // R7 lost pulse absent on non-Stop edges
    can_act = 1; step(); can_act = 0;
    chk("R7 can_act in Run no loss", can_lost, 0);

    // R10 external reset request from Stop
    stop_req = 1; step(); stop_req = 0;
    ext_rst_req = 1; step(); ext_rst_req = 0;
    chk("R10 ext mode", mode, 0);
    chk("R10 ext pce all ones", per_ce, 15);
    chk("R10 ext cause", rst_cause, 1);

    pce_wr = 1; pce_wdata = 4'h5; step(); pce_wr = 0;
    wait_req = 1; step(); wait_req = 0;
    wdog_rst_req = 1; step(); wdog_rst_req = 0;
    chk("R10 wdog mode", mode, 0);
    chk("R10 wdog pce", per_ce, 15);
    chk("R10 wdog cause", rst_cause, 2);

    ext_rst_req = 1; wdog_rst_req = 1; step(); ext_rst_req = 0; wdog_rst_req = 0;
    chk("R10 ext priority", rst_cause, 1);

    // R2 power-on reset clears cause again
    stop_req = 1; step(); stop_req = 0;
    rst = 1; repeat (3) @(negedge clk); rst = 0;
    align();
    chk("R2 por mode", mode, 0);
    chk("R2 por cause", rst_cause, 0);
    chk("R2 por per_ce", per_ce, 15);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule